// File: doc/BRIEF.md
# T1 Transmit Frame Formatter

This block turns parallel channel bytes into the serial 1.544 Mb/s T1 line stream. Each frame is 193 bit slots: one framing bit, then 24 channels of 8 bits each, sent MSB first. Frames are grouped into a multiframe of 12 frames (superframe) or 24 frames (extended superframe), chosen by a static mode input. The block advances one bit slot on every cycle where the bit-rate enable is high. It asks for each channel byte through `byte_req` and `chan_idx`, and samples `chan_data` in the slot where that byte's first bit goes out.

The framing bit comes from one of three sources, depending on the mode and the frame number: a fixed alignment pattern, the external link input, or a CRC-6 remainder that the block computes over the previous multiframe. When signaling is enabled, one signaling bit replaces the LSB of every channel in every sixth frame. Two more options act on each channel byte: all-zero bytes can be stuffed to keep ones density, and in superframe mode a yellow alarm can be sent.

The serial bit comes out of a register together with frame and multiframe markers. Each output changes one clock after the enable cycle that produced it.

Top module: `t1_tx_formatter`

## Requirements
- R1: Frame layout. A frame is 193 slots: the framing slot, then channels 0..23 of 8 bits each, MSB first. `byte_req` is high, with `chan_idx` = n, only in the slot of channel n's first bit. `chan_data` is sampled in that slot alone, and later changes to it do not affect that byte.
- R2: `line_bit`, `frame_sync` and `mf_sync` are registered and change only on the clock edge that ends a cycle with `bit_en` high. `frame_sync` is 1 while `line_bit` carries a framing bit. `mf_sync` is 1 while it carries the framing bit of frame 1.
- R3: A multiframe has 12 frames when `esf_mode`=0 and 24 frames when `esf_mode`=1. The frame count restarts at frame 1 after the last frame.
- R4: Superframe mode with `ext_sbit`=0. The framing bits of frames 1,3,5,7,9,11 are 1,0,1,0,1,0. The framing bits of frames 2,4,6,8,10,12 are 0,0,1,1,1,0.
- R5: Superframe mode with `ext_sbit`=1. The framing bit of each even frame is `link_bit` as sampled in that slot. The odd frames still follow R4.
- R6: Extended superframe mode. The framing bit of each odd frame is `link_bit` as sampled in that slot. `ext_sbit` has no effect in this mode.
- R7: Extended superframe mode. The framing bits of frames 4,8,12,16,20,24 are 0,0,1,0,1,1.
- R8: Extended superframe mode. Frames 2,6,10,14,18,22 carry remainder bits 5 down to 0 of a CRC-6 (x^6+x+1). The CRC starts from zero, takes bits MSB first, and runs over all 4632 slots of the previous multiframe, with each framing slot counted as 1. The first multiframe after reset sends zeros in these frames.
- R9: When `sig_en`=1, `sig_bit` as sampled in the slot replaces the LSB (8th bit) of every channel in frames 6 and 12 (superframe) or 6, 12, 18 and 24 (extended). Channel LSBs in other frames are not changed. When `sig_en`=0, no LSB is replaced.
- R10: When `b7_stuff_en`=1, a channel byte of 0x00 is sent as 0x02. When `b7_stuff_en`=0, it is sent as 0x00.
- R11: When `yellow_en`=1 in superframe mode, the second bit sent in every channel (byte bit 6) is 0. In extended superframe mode, `yellow_en` has no effect.
- R12: While `rst` is high, `line_bit`, `frame_sync`, `mf_sync` and `byte_req` are 0 and `chan_idx` is 0. The first enabled slot after reset is the framing bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; one slot per high cycle |
| esf_mode | input | 1 | 0 = 12-frame superframe, 1 = 24-frame extended superframe |
| ext_sbit | input | 1 | Superframe only: even-frame framing bits taken from `link_bit` |
| sig_en | input | 1 | Enable robbed-bit signaling |
| yellow_en | input | 1 | Superframe yellow alarm |
| b7_stuff_en | input | 1 | Enable zero-byte stuffing |
| chan_data | input | 8 | Byte for the channel named by `chan_idx` |
| sig_bit | input | 1 | Signaling bit for the current slot |
| link_bit | input | 1 | Link / data-link bit for the current framing slot |
| byte_req | output | 1 | Current slot is the first bit of a channel |
| chan_idx | output | 5 | Channel of the current slot |
| line_bit | output | 1 | Serial T1 bit |
| frame_sync | output | 1 | `line_bit` is a framing bit |
| mf_sync | output | 1 | `line_bit` is the framing bit of frame 1 |

## Verification
The assertions assume that `esf_mode` changes only while `rst` is high. A mode change in the middle of a multiframe could leave the frame count above the new limit. They also assume that `chan_data` is valid in every cycle where `byte_req` and `bit_en` are both high. The stimulus changes all mode inputs only while reset is held. It drives `chan_data` with the byte for the channel that its own slot model expects, every cycle. Some runs use gapped `bit_en` patterns, so stalled cycles must leave every output unchanged.

// File: rtl/t1_fmt_pkg.sv
`timescale 1ns/1ps
package t1_fmt_pkg;

    localparam int NUM_CH     = 24;
    localparam int CH_BITS    = 8;
    localparam int SF_LEN     = 12;
    localparam int ESF_LEN    = 24;
    localparam int SIG_PERIOD = 6;
    localparam int CRC_W      = 6;
    localparam int FRAME_BITS = 1 + NUM_CH * CH_BITS;
    localparam int CHW        = $clog2(NUM_CH);
    localparam int BW         = $clog2(CH_BITS);
    localparam int FRW        = $clog2(ESF_LEN);
    localparam int PATW       = $clog2(CRC_W);

    // index k of each pattern = k-th frame of that kind
    localparam logic [CRC_W-1:0] SF_SIGFRAME_PAT = 6'b011100;
    localparam logic [CRC_W-1:0] ESF_ALIGN_PAT   = 6'b110100;
    localparam logic [CRC_W-1:0] CRC_POLY        = 6'b000011;

    typedef struct packed {
        logic           fslot;
        logic [CHW-1:0] chan;
        logic [BW-1:0]  bitn;
        logic [FRW-1:0] frame;
        logic           mf_last;
    } slot_t;

    typedef enum logic [2:0] {
        FK_TERM,
        FK_SIGALIGN,
        FK_ESFALIGN,
        FK_LINK,
        FK_CRC
    } fkind_e;

    function automatic fkind_e fbit_kind(logic esf, logic ext, logic [FRW-1:0] fr);
        if (!esf) begin
            if (!fr[0])   return FK_TERM;
            else if (ext) return FK_LINK;
            else          return FK_SIGALIGN;
        end
        if (!fr[0])       return FK_LINK;
        else if (fr[1])   return FK_ESFALIGN;
        return FK_CRC;
    endfunction

    function automatic logic [CRC_W-1:0] crc6_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [CH_BITS-1:0] b7_stuff(logic [CH_BITS-1:0] d, logic en);
        if (en && d == '0) return CH_BITS'(2);
        return d;
    endfunction

    function automatic logic is_sig_frame(logic [FRW-1:0] fr);
        return (int'(fr) % SIG_PERIOD) == SIG_PERIOD - 1;
    endfunction

endpackage

// File: rtl/t1_slot_counter.sv
`timescale 1ns/1ps
module t1_slot_counter
    import t1_fmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  logic  esf_mode,
    output slot_t slot
);

    logic           fslot_q;
    logic [CHW-1:0] chan_q;
    logic [BW-1:0]  bit_q;
    logic [FRW-1:0] frame_q;
    logic [FRW-1:0] last_frame;
    logic           chan_end;
    logic           frame_end;

    assign last_frame = esf_mode ? FRW'(ESF_LEN - 1) : FRW'(SF_LEN - 1);
    assign chan_end   = !fslot_q && (bit_q == BW'(CH_BITS - 1));
    assign frame_end  = chan_end && (chan_q == CHW'(NUM_CH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fslot_q <= 1'b1;
            chan_q  <= '0;
            bit_q   <= '0;
            frame_q <= '0;
        end else if (bit_en) begin
            if (fslot_q) begin
                fslot_q <= 1'b0;
            end else if (chan_end) begin
                bit_q <= '0;
                if (frame_end) begin
                    chan_q  <= '0;
                    fslot_q <= 1'b1;
                    frame_q <= (frame_q == last_frame) ? '0 : frame_q + 1'b1;
                end else begin
                    chan_q <= chan_q + 1'b1;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign slot.fslot   = fslot_q;
    assign slot.chan    = chan_q;
    assign slot.bitn    = bit_q;
    assign slot.frame   = frame_q;
    assign slot.mf_last = frame_end && (frame_q == last_frame);

    // R3
    frame_limit_chk: assert property (@(posedge clk) disable iff (rst)
        frame_q <= last_frame);

endmodule

// File: rtl/t1_fbit_source.sv
`timescale 1ns/1ps
module t1_fbit_source
    import t1_fmt_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_en,
    input  logic           esf_mode,
    input  logic           ext_sbit,
    input  logic           link_bit,
    input  logic           fslot,
    input  logic [FRW-1:0] frame,
    input  logic           mf_last,
    input  logic           sent_bit,
    output logic           fbit
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_hold_q;
    logic [CRC_W-1:0] crc_next;
    logic [PATW-1:0]  idx;
    fkind_e           kind;

    assign kind = fbit_kind(esf_mode, ext_sbit, frame);
    assign idx  = esf_mode ? PATW'(frame >> 2) : PATW'(frame >> 1);

    always_comb begin
        case (kind)
            FK_TERM:     fbit = ~idx[0];
            FK_SIGALIGN: fbit = SF_SIGFRAME_PAT[idx];
            FK_ESFALIGN: fbit = ESF_ALIGN_PAT[idx];
            FK_LINK:     fbit = link_bit;
            FK_CRC:      fbit = crc_hold_q[PATW'(CRC_W - 1) - idx];
            default:     fbit = 1'b0;
        endcase
    end

    // framing slots enter the check sequence as ones
    assign crc_next = crc6_step(crc_q, fslot ? 1'b1 : sent_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q      <= '0;
            crc_hold_q <= '0;
        end else if (bit_en) begin
            if (mf_last) begin
                crc_hold_q <= crc_next;
                crc_q      <= '0;
            end else begin
                crc_q <= crc_next;
            end
        end
    end

    // R8
    crc_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && mf_last) |=> (crc_q == '0));

endmodule

// File: rtl/t1_chan_shaper.sv
`timescale 1ns/1ps
module t1_chan_shaper
    import t1_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               esf_mode,
    input  logic               sig_en,
    input  logic               yellow_en,
    input  logic               b7_stuff_en,
    input  logic               sig_bit,
    input  logic [CH_BITS-1:0] chan_data,
    input  logic               fslot,
    input  logic [BW-1:0]      bitn,
    input  logic [FRW-1:0]     frame,
    output logic               byte_req,
    output logic               data_bit
);

    logic [CH_BITS-1:0] proc;
    logic [CH_BITS-1:0] byte_q;
    logic [CH_BITS-1:0] cur;
    logic [BW-1:0]      sel;
    logic               lsb_slot;

    always_comb begin
        proc = b7_stuff(chan_data, b7_stuff_en);
        if (yellow_en && !esf_mode) proc[CH_BITS-2] = 1'b0;
    end

    assign byte_req = !fslot && (bitn == '0);

    always_ff @(posedge clk) begin
        if (rst) byte_q <= '0;
        else if (bit_en && byte_req) byte_q <= proc;
    end

    assign cur      = byte_req ? proc : byte_q;
    assign sel      = BW'(CH_BITS - 1) - bitn;
    assign lsb_slot = (bitn == BW'(CH_BITS - 1));
    assign data_bit = (sig_en && lsb_slot && is_sig_frame(frame)) ? sig_bit : cur[sel];

    // R10
    stuff_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && byte_req && b7_stuff_en) |=> (byte_q != '0));

    // R11
    yellow_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && byte_req && yellow_en && !esf_mode) |=> !byte_q[CH_BITS-2]);

endmodule

// File: rtl/t1_tx_formatter.sv
`timescale 1ns/1ps
module t1_tx_formatter
    import t1_fmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               esf_mode,
    input  logic               ext_sbit,
    input  logic               sig_en,
    input  logic               yellow_en,
    input  logic               b7_stuff_en,
    input  logic [CH_BITS-1:0] chan_data,
    input  logic               sig_bit,
    input  logic               link_bit,
    output logic               byte_req,
    output logic [CHW-1:0]     chan_idx,
    output logic               line_bit,
    output logic               frame_sync,
    output logic               mf_sync
);

    slot_t slot;
    logic  fbit;
    logic  data_bit;
    logic  line_next;

    t1_slot_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .esf_mode (esf_mode),
        .slot     (slot)
    );

    t1_fbit_source u_fsrc (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .esf_mode (esf_mode),
        .ext_sbit (ext_sbit),
        .link_bit (link_bit),
        .fslot    (slot.fslot),
        .frame    (slot.frame),
        .mf_last  (slot.mf_last),
        .sent_bit (line_next),
        .fbit     (fbit)
    );

    t1_chan_shaper u_shp (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .esf_mode    (esf_mode),
        .sig_en      (sig_en),
        .yellow_en   (yellow_en),
        .b7_stuff_en (b7_stuff_en),
        .sig_bit     (sig_bit),
        .chan_data   (chan_data),
        .fslot       (slot.fslot),
        .bitn        (slot.bitn),
        .frame       (slot.frame),
        .byte_req    (byte_req),
        .data_bit    (data_bit)
    );

    assign chan_idx  = slot.chan;
    assign line_next = slot.fslot ? fbit : data_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_bit   <= 1'b0;
            frame_sync <= 1'b0;
            mf_sync    <= 1'b0;
        end else if (bit_en) begin
            line_bit   <= line_next;
            frame_sync <= slot.fslot;
            mf_sync    <= slot.fslot && (slot.frame == '0);
        end
    end

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(line_bit) && $stable(frame_sync) && $stable(mf_sync)));

    // R2
    mf_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        mf_sync |-> frame_sync);

endmodule

// File: tb/t1_tx_formatter_bench.sv
`timescale 1ns/1ps
module t1_tx_formatter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       esf_mode = 1'b0, ext_sbit = 1'b0, sig_en = 1'b0;
    logic       yellow_en = 1'b0, b7_stuff_en = 1'b0;
    logic [7:0] chan_data = 8'h00;
    logic       sig_bit = 1'b0, link_bit = 1'b0;
    logic       byte_req;
    logic [4:0] chan_idx;
    logic       line_bit, frame_sync, mf_sync;

    always #2.5 clk = ~clk;

    t1_tx_formatter u_t1_tx_formatter (
        .clk(clk), .rst(rst), .bit_en(bit_en), .esf_mode(esf_mode),
        .ext_sbit(ext_sbit), .sig_en(sig_en), .yellow_en(yellow_en),
        .b7_stuff_en(b7_stuff_en), .chan_data(chan_data), .sig_bit(sig_bit),
        .link_bit(link_bit), .byte_req(byte_req), .chan_idx(chan_idx),
        .line_bit(line_bit), .frame_sync(frame_sync), .mf_sync(mf_sync)
    );

    int checks = 0;
    int errors = 0;

    // fields: [15] esf [14] ext [13] sig [12] yellow [11] stuff [10] gaps [9:8] multiframes [7:0] seed
    localparam int NV = 6;
    localparam logic [15:0] VECS [NV] = '{16'h0211, 16'h7E5A, 16'h29C3,
                                          16'hA33C, 16'hDE99, 16'hAA07};
    localparam logic [5:0] FS_PAT  = 6'b011100;
    localparam logic [5:0] FPS_PAT = 6'b110100;

    int         m_pos, m_fr, m_len;
    logic [5:0] m_crc, m_hold;
    logic       exp_line, exp_fs, exp_mf;
    int         exp_kind;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] seed;
    int eF, eC, eD, eS, eM;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] data_of(int fr, int ch, logic [7:0] sd);
        if (ch % 5 == 0) return 8'h00;
        return 8'(fr * 37 + ch * 11 + int'(sd));
    endfunction

    task automatic model_step();
        logic b, v, fb;
        logic [7:0] by;
        int n, ch, bi;
        n = m_fr + 1;
        if (m_pos == 0) begin
            exp_kind = 0;
            if (!esf_mode) begin
                if (n % 2 == 1)   b = ((m_fr / 2) % 2 == 0);
                else if (ext_sbit) b = link_bit;
                else              b = FS_PAT[m_fr / 2];
            end else begin
                if (n % 2 == 1)      b = link_bit;
                else if (n % 4 == 0) b = FPS_PAT[n / 4 - 1];
                else begin
                    b = m_hold[5 - (n - 2) / 4];
                    exp_kind = 1;
                end
            end
        end else begin
            ch = (m_pos - 1) / 8;
            bi = (m_pos - 1) % 8;
            by = data_of(m_fr, ch, seed);
            if (b7_stuff_en && by == 8'h00) by = 8'h02;
            if (yellow_en && !esf_mode) by[6] = 1'b0;
            b = by[7 - bi];
            exp_kind = 2;
            if (sig_en && (m_fr % 6 == 5) && bi == 7) begin
                b = sig_bit;
                exp_kind = 3;
            end
        end
        exp_line = b;
        exp_fs   = (m_pos == 0);
        exp_mf   = (m_pos == 0) && (m_fr == 0);
        v  = (m_pos == 0) ? 1'b1 : b;
        fb = m_crc[5] ^ v;
        m_crc = {m_crc[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
        if (m_pos == 192 && m_fr == m_len - 1) begin
            m_hold = m_crc;
            m_crc  = '0;
        end
        if (m_pos == 192) begin
            m_pos = 0;
            m_fr  = (m_fr == m_len - 1) ? 0 : m_fr + 1;
        end else begin
            m_pos = m_pos + 1;
        end
    endtask

    task automatic compare_now();
        logic exp_req;
        exp_req = (m_pos != 0) && ((m_pos - 1) % 8 == 0);
        if (line_bit !== exp_line) begin
            case (exp_kind)
                0: eF++;
                1: eC++;
                2: eD++;
                default: eS++;
            endcase
        end
        if (frame_sync !== exp_fs || mf_sync !== exp_mf) eM++;
        if (byte_req !== exp_req) eM++;
        else if (exp_req && chan_idx !== 5'((m_pos - 1) / 8)) eM++;
    endtask

    task automatic run_vector(input logic [15:0] v);
        int total, done, cyc;
        rst = 1'b1;
        bit_en = 1'b0;
        esf_mode = v[15]; ext_sbit = v[14]; sig_en = v[13];
        yellow_en = v[12]; b7_stuff_en = v[11];
        seed = v[7:0];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pos = 0; m_fr = 0; m_len = esf_mode ? 24 : 12;
        m_crc = '0; m_hold = '0;
        exp_line = 0; exp_fs = 0; exp_mf = 0; exp_kind = 2;
        eF = 0; eC = 0; eD = 0; eS = 0; eM = 0;
        total = int'(v[9:8]) * m_len * 193;
        done = 0; cyc = 0;
        while (done < total) begin
            compare_now();
            bit_en    = v[10] ? (cyc % 3 != 0) : 1'b1;
            link_bit  = lfsr[0];
            sig_bit   = lfsr[3];
            chan_data = data_of(m_fr, (m_pos > 0) ? (m_pos - 1) / 8 : 0, seed);
            if (bit_en) begin
                model_step();
                done++;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc++;
            @(negedge clk);
        end
        compare_now();
        bit_en = 1'b0;
        if (!esf_mode)
            check(eF == 0, ext_sbit ? "R5" : "R4", "framing bit mismatches", eF, 0);
        else begin
            check(eF == 0, "R6 R7", "framing bit mismatches", eF, 0);
            check(eC == 0, "R8", "CRC bit mismatches", eC, 0);
        end
        check(eD == 0, "R1 R10 R11", "channel bit mismatches", eD, 0);
        if (sig_en) check(eS == 0, "R9", "signaling bit mismatches", eS, 0);
        check(eM == 0, "R1 R2 R3", "marker/request mismatches", eM, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        // vector table walk
        for (int i = 0; i < NV; i++) run_vector(VECS[i]);

        // R12: reset state, with bit_en held high during reset
        rst = 1'b1; bit_en = 1'b1;
        esf_mode = 1'b0; ext_sbit = 1'b0; sig_en = 1'b0;
        yellow_en = 1'b1; b7_stuff_en = 1'b1;
        repeat (2) @(negedge clk);
        check(line_bit == 1'b0 && frame_sync == 1'b0 && mf_sync == 1'b0,
              "R12", "outputs in reset", {line_bit, frame_sync, mf_sync}, 0);
        check(byte_req == 1'b0 && chan_idx == 5'd0, "R12", "request in reset",
              {byte_req, chan_idx}, 0);
        // R2: no enable, no change
        rst = 1'b0; bit_en = 1'b0;
        repeat (3) @(negedge clk);
        check(line_bit == 1'b0 && frame_sync == 1'b0, "R2", "hold while disabled",
              {line_bit, frame_sync}, 0);
        // first slot is frame 1 framing bit (value 1)
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        check({line_bit, frame_sync, mf_sync} == 3'b111, "R12 R4", "first framing slot",
              {line_bit, frame_sync, mf_sync}, 7);
        repeat (4) @(negedge clk);
        check({line_bit, frame_sync, mf_sync} == 3'b111, "R2", "hold after framing bit",
              {line_bit, frame_sync, mf_sync}, 7);
        check(byte_req == 1'b1 && chan_idx == 5'd0, "R1", "request channel 0",
              {byte_req, chan_idx}, 32);
        // R10: zero byte stuffed; later chan_data changes ignored (R1)
        got = '0;
        chan_data = 8'h00;
        for (int k = 0; k < 8; k++) begin
            bit_en = 1'b1;
            @(negedge clk);
            chan_data = 8'hFF;
            got = {got[6:0], line_bit};
        end
        check(got == 8'h02, "R10 R1", "stuffed zero byte", got, 8'h02);
        check(byte_req == 1'b1 && chan_idx == 5'd1, "R1", "request channel 1",
              {byte_req, chan_idx}, 33);
        // R11: yellow clears bit 6 of 0xFF
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            got = {got[6:0], line_bit};
        end
        bit_en = 1'b0;
        check(got == 8'hBF, "R11", "yellow alarm byte", got, 8'hBF);
        check(frame_sync == 1'b0, "R2", "frame marker low in channel", frame_sync, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule